// File: doc/BRIEF.md
# Inbound Write Posting Policy Unit

This unit sits on the PCI target side of a bridge into an internal interconnect. For every inbound request it decides whether the PCI side may finish the cycle at once (posted) or must wait until the internal side confirms it (confirmed). It also decides whether the request packet sent inward asks for a response. Memory writes are posted but still ask for a response, so that a later I/O write cannot overtake them. I/O writes are posted by address: the primary disk data port follows its own control bit, and every other address follows the lowest-numbered matching region.

The unit also tracks the one confirmed request that may be outstanding. Every further request is answered with Retry until that response completes. A response marked with the exception or SMI flag is held while hold mode is enabled: the bus stays held until the pending interrupt-context transfer reports done, and only then does the completion go out. A separate outbound path reports a Master Abort as the exception flag on the returned response.

Top module: `write_post_policy`

## Requirements
- R1: While rstN is low, and on the first cycle after it, every output is 0 and no request is outstanding.
- R2: Request command codes are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 register read, 5 register write; codes 6 and 7 are handled as reads. An accepted memory write (code 1) is posted whatever its address or region, and decSendRsp is 1 for it.
- R3: An accepted I/O write whose address bits above bit 1 select byte addresses 1F0h to 1F3h is posted only when postIdeEn is 1. When postIdeEn is 0 it is confirmed. The region inputs play no part for these addresses.
- R4: An accepted I/O write to any other address looks at the lowest-index set bit of regionHit. It is posted only if that region has both regionIsIo and regionPrefetch set. With no bit set it is confirmed.
- R5: Every accepted request other than a memory write has decSendRsp at 1. Reads and register writes are always confirmed.
- R6: decValid pulses in the cycle after each cycle in which reqValid is 1, and only then. decPost, decSendRsp and decRetry are valid with it.
- R7: While a confirmed request is outstanding or a hold is active, every request is answered with decRetry at 1, and decPost and decSendRsp at 0.
- R8: If holdEn is 1 and a response arrives with rspExcep or rspSmi set, holdBus is 1 from the next cycle and cplDone stays 0. In the cycle after xferDone, holdBus falls, cplDone pulses and the outstanding request is released.
- R9: A response with both flags clear, or one that arrives while holdEn is 0, gives a cplDone pulse in the next cycle and releases the outstanding request. A request in that following cycle is accepted.
- R10: When obDone is 1, obRspValid is 1 in the next cycle and obRspExcep equals obMasterAbort from that cycle.
- R11: An accepted posted write does not make later requests retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Inbound request present this cycle |
| reqCmd | input | 3 | Request command code |
| reqAddr | input | ADDR_W | Request address |
| regionHit | input | NREG | Region match vector |
| regionIsIo | input | NREG | Region space is I/O |
| regionPrefetch | input | NREG | Region prefetchable bit |
| postIdeEn | input | 1 | Post writes to the disk data port |
| holdEn | input | 1 | Hold flagged responses |
| rspValid | input | 1 | Internal response arrives |
| rspExcep | input | 1 | Response exception flag |
| rspSmi | input | 1 | Response SMI flag |
| xferDone | input | 1 | Pending interrupt-context transfer finished |
| obDone | input | 1 | Outbound transaction ended |
| obMasterAbort | input | 1 | Outbound transaction ended in Master Abort |
| decValid | output | 1 | Decision for the previous cycle's request |
| decPost | output | 1 | Request posted |
| decSendRsp | output | 1 | Inward packet asks for a response |
| decRetry | output | 1 | Request answered with Retry |
| cplDone | output | 1 | Confirmed request completes on PCI |
| holdBus | output | 1 | Completion held, bus held |
| obRspValid | output | 1 | Outbound response returned |
| obRspExcep | output | 1 | Exception flag of that response |

## Verification
The hardest case to reach from the ports is the release edge of a hold. A flagged response must arrive while a confirmed write is outstanding, a new request must land during the hold and be retried, and then xferDone must come. The cycle after xferDone has to show cplDone with holdBus already low, and a request in the cycle after that must be accepted. The stimulus first issues a confirmed I/O write to the disk data port with posting off. It then sends a flagged response with holdEn set, sends a request inside the hold, and fires xferDone, with the reference model checking every cycle. The priority case, where a lower region that is not posted masks a higher one that is, is driven with two region bits set together.

// File: rtl/wpp_pkg.sv
package wpp_pkg;

  typedef enum logic [2:0] {
    CMD_MEM_RD = 3'd0,
    CMD_MEM_WR = 3'd1,
    CMD_IO_RD  = 3'd2,
    CMD_IO_WR  = 3'd3,
    CMD_REG_RD = 3'd4,
    CMD_REG_WR = 3'd5
  } wppCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;  // request accepted this cycle
    logic retry;  // request refused this cycle
    logic cpl;    // completion released this cycle
    logic hold;   // hold currently active
  } wppStrobe_t;

endpackage

// File: rtl/wpp_datapath.sv
module wpp_datapath
  import wpp_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned NREG          = 16,
  parameter int unsigned IDE_PORT      = 'h1F0,
  parameter bit          FORCE_MEM_RSP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [NREG-1:0]   regionHit,
  input  logic [NREG-1:0]   regionIsIo,
  input  logic [NREG-1:0]   regionPrefetch,
  input  logic              postIdeEn,
  input  logic              obDone,
  input  logic              obMasterAbort,
  input  wppStrobe_t        stb,
  output logic              needConfirm,
  output logic              decValid,
  output logic              decPost,
  output logic              decSendRsp,
  output logic              decRetry,
  output logic              cplDone,
  output logic              obRspValid,
  output logic              obRspExcep
);

  localparam logic [ADDR_W-1:0] IDE_ADDR  = ADDR_W'(IDE_PORT);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

  logic [NREG-1:0] anyBelow;
  logic [NREG-1:0] regionPostVec;
  logic            regionPost;
  logic            ideHit;
  logic            memWrRsp;
  logic            postNow;
  logic            rspNow;

  // lowest-index matching region decides
  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_region
      if (gi == 0) begin : g_first
        assign anyBelow[gi] = 1'b0;
      end else begin : g_rest
        assign anyBelow[gi] = anyBelow[gi-1] | regionHit[gi-1];
      end
      assign regionPostVec[gi] = regionHit[gi] & ~anyBelow[gi]
                               & regionIsIo[gi] & regionPrefetch[gi];
    end
    if (FORCE_MEM_RSP) begin : g_memRspOn
      assign memWrRsp = 1'b1;
    end else begin : g_memRspOff
      assign memWrRsp = 1'b0;
    end
  endgenerate

  assign regionPost = |regionPostVec;
  assign ideHit     = (reqAddr & WORD_MASK) == (IDE_ADDR & WORD_MASK);

  always_comb begin
    postNow = 1'b0;
    rspNow  = 1'b1;
    case (reqCmd)
      CMD_MEM_WR: begin
        postNow = 1'b1;
        rspNow  = memWrRsp;
      end
      CMD_IO_WR:  postNow = ideHit ? postIdeEn : regionPost;
      default:    postNow = 1'b0;
    endcase
  end

  assign needConfirm = ~postNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid   <= 1'b0;
      decPost    <= 1'b0;
      decSendRsp <= 1'b0;
      decRetry   <= 1'b0;
      cplDone    <= 1'b0;
      obRspValid <= 1'b0;
      obRspExcep <= 1'b0;
    end else begin
      decValid   <= reqValid;
      decPost    <= stb.issue & postNow;
      decSendRsp <= stb.issue & rspNow;
      decRetry   <= stb.retry;
      cplDone    <= stb.cpl;
      obRspValid <= obDone;
      obRspExcep <= obDone & obMasterAbort;
    end
  end

endmodule

// File: rtl/wpp_ctrl.sv
module wpp_ctrl
  import wpp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       needConfirm,
  input  logic       holdEn,
  input  logic       rspValid,
  input  logic       rspExcep,
  input  logic       rspSmi,
  input  logic       xferDone,
  output wppStrobe_t stb
);

  logic busy;
  logic holding;
  logic blocked;
  logic flagged;
  logic startHold;
  logic releaseEvt;
  logic confirmEvt;

  assign blocked    = busy | holding;
  assign flagged    = rspExcep | rspSmi;
  assign startHold  = ~holding & rspValid & holdEn & flagged;
  assign releaseEvt = holding ? xferDone : (rspValid & ~(holdEn & flagged));
  assign confirmEvt = reqValid & ~blocked & needConfirm;

  always_comb begin
    stb.issue = reqValid & ~blocked;
    stb.retry = reqValid & blocked;
    stb.cpl   = releaseEvt;
    stb.hold  = holding;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      holding <= 1'b0;
    end else begin
      busy    <= (busy & ~releaseEvt) | confirmEvt;
      holding <= startHold | (holding & ~xferDone);
    end
  end

endmodule

// File: rtl/write_post_policy.sv
module write_post_policy
  import wpp_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned NREG          = 16,
  parameter int unsigned IDE_PORT      = 'h1F0,
  parameter bit          FORCE_MEM_RSP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [NREG-1:0]   regionHit,
  input  logic [NREG-1:0]   regionIsIo,
  input  logic [NREG-1:0]   regionPrefetch,
  input  logic              postIdeEn,
  input  logic              holdEn,
  input  logic              rspValid,
  input  logic              rspExcep,
  input  logic              rspSmi,
  input  logic              xferDone,
  input  logic              obDone,
  input  logic              obMasterAbort,
  output logic              decValid,
  output logic              decPost,
  output logic              decSendRsp,
  output logic              decRetry,
  output logic              cplDone,
  output logic              holdBus,
  output logic              obRspValid,
  output logic              obRspExcep
);

  wppStrobe_t stb;
  logic       needConfirm;

  wpp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .needConfirm(needConfirm),
    .holdEn(holdEn), .rspValid(rspValid), .rspExcep(rspExcep),
    .rspSmi(rspSmi), .xferDone(xferDone), .stb(stb)
  );

  wpp_datapath #(
    .ADDR_W(ADDR_W), .NREG(NREG), .IDE_PORT(IDE_PORT),
    .FORCE_MEM_RSP(FORCE_MEM_RSP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .regionHit(regionHit), .regionIsIo(regionIsIo),
    .regionPrefetch(regionPrefetch), .postIdeEn(postIdeEn),
    .obDone(obDone), .obMasterAbort(obMasterAbort), .stb(stb),
    .needConfirm(needConfirm), .decValid(decValid), .decPost(decPost),
    .decSendRsp(decSendRsp), .decRetry(decRetry), .cplDone(cplDone),
    .obRspValid(obRspValid), .obRspExcep(obRspExcep)
  );

  assign holdBus = stb.hold;

endmodule

// File: rtl/wpp_checker.sv
module wpp_checker
  import wpp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [2:0] reqCmd,
  input logic       holdEn,
  input logic       rspValid,
  input logic       decValid,
  input logic       decPost,
  input logic       decSendRsp,
  input logic       decRetry,
  input logic       cplDone,
  input logic       holdBus,
  input logic       obRspValid,
  input logic       obRspExcep
);

  AST_RETRY_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    decRetry |-> (!decPost && !decSendRsp)); // R7

  AST_DEC_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> decValid); // R6

  AST_NO_DEC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !decValid); // R6

  AST_MEMWR_POSTED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCmd == CMD_MEM_WR) |=> (decRetry || (decPost && decSendRsp))); // R2

  AST_HOLD_NO_CPL: assert property (@(posedge clk) disable iff (!rstN)
    holdBus |-> !cplDone); // R8

  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdBus) |-> ($past(holdEn) && $past(rspValid))); // R8

  AST_OB_EXCEP_VALID: assert property (@(posedge clk) disable iff (!rstN)
    obRspExcep |-> obRspValid); // R10

endmodule

bind write_post_policy wpp_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
  .holdEn(holdEn), .rspValid(rspValid), .decValid(decValid),
  .decPost(decPost), .decSendRsp(decSendRsp), .decRetry(decRetry),
  .cplDone(cplDone), .holdBus(holdBus), .obRspValid(obRspValid),
  .obRspExcep(obRspExcep)
);

// File: tb/tb_write_post_policy.sv
module tb_write_post_policy;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqCmd = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [NREG-1:0] regionHit = '0;
  logic [NREG-1:0] regionIsIo = 16'h00A0;      // regions 5 and 7 are I/O
  logic [NREG-1:0] regionPrefetch = 16'h0228;  // regions 3, 5, 9 prefetchable
  logic postIdeEn = 1'b0, holdEn = 1'b0;
  logic rspValid = 1'b0, rspExcep = 1'b0, rspSmi = 1'b0, xferDone = 1'b0;
  logic obDone = 1'b0, obMasterAbort = 1'b0;
  logic decValid, decPost, decSendRsp, decRetry, cplDone, holdBus, obRspValid, obRspExcep;

  int testCount = 0;
  int failCount = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  bit mBusy, mHold;
  bit eValid, ePost, eRsp, eRetry, eCpl, eHold, eObV, eObE;

  write_post_policy dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit refPost(input int cmd, input int addr, input logic [NREG-1:0] hit);
    if (cmd == 1) return 1;
    if (cmd != 3) return 0;
    if ((addr / 4) == ('h1F0 / 4)) return postIdeEn;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) return regionIsIo[i] && regionPrefetch[i];
    return 0;
  endfunction

  task automatic modelStep();
    bit p;
    bit nb, nh, cpl;
    if (!rstN) begin
      mBusy = 0; mHold = 0;
      {eValid, ePost, eRsp, eRetry, eCpl, eHold, eObV, eObE} = '0;
      return;
    end
    eValid = reqValid; ePost = 0; eRsp = 0; eRetry = 0;
    nb = mBusy; nh = mHold; cpl = 0;
    if (mHold) begin
      if (xferDone) begin cpl = 1; nh = 0; end
    end else if (rspValid) begin
      if (holdEn && (rspExcep || rspSmi)) nh = 1;
      else cpl = 1;
    end
    if (cpl) nb = 0;
    if (reqValid) begin
      if (mBusy || mHold) eRetry = 1;
      else begin
        p = refPost(int'(reqCmd), int'(reqAddr), regionHit);
        ePost = p; eRsp = 1;
        if (!p) nb = 1;
      end
    end
    eCpl = cpl;
    mBusy = nb; mHold = nh; eHold = nh;
    eObV = obDone; eObE = obDone && obMasterAbort;
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    testCount++;
    if ({decValid, decPost, decSendRsp, decRetry, cplDone, holdBus, obRspValid, obRspExcep} !==
        {eValid, ePost, eRsp, eRetry, eCpl, eHold, eObV, eObE}) begin
      failCount++;
      $display("FAIL %s: got v%b p%b s%b r%b c%b h%b ov%b oe%b expected v%b p%b s%b r%b c%b h%b ov%b oe%b",
        tag, decValid, decPost, decSendRsp, decRetry, cplDone, holdBus, obRspValid, obRspExcep,
        eValid, ePost, eRsp, eRetry, eCpl, eHold, eObV, eObE);
    end
    reqValid = 0; rspValid = 0; rspExcep = 0; rspSmi = 0; xferDone = 0; obDone = 0; obMasterAbort = 0;
  endtask

  task automatic req(input int cmd, input int addr, input logic [NREG-1:0] hit, input string tag);
    reqValid = 1; reqCmd = 3'(cmd); reqAddr = ADDR_W'(addr); regionHit = hit;
    cyc(tag);
  endtask

  task automatic rsp(input bit ex, input bit smi, input string tag);
    rspValid = 1; rspExcep = ex; rspSmi = smi;
    cyc(tag);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failCount++;
      $display("FAIL watchdog: got hang expected completion");
      finishRun();
    end
  end

  initial begin
    cyc("R1 in reset");
    cyc("R1 in reset");
    rstN = 1;
    cyc("R1 after reset");

    // R2 memory writes post with response request
    req(1, 'h1F0, 16'h0000, "R2 memwr ide addr");
    req(1, 'h4000, 16'h0080, "R2 memwr io region");
    req(1, 'h4004, 16'h0000, "R11 posted no block");
    cyc("R6 idle");

    // R3 disk data port, posting off -> confirmed
    req(3, 'h1F0, 16'h0020, "R3 ide confirmed");
    req(1, 'h10, 16'h0, "R7 retry while busy");
    rsp(0, 0, "R9 plain response");
    req(3, 'h300, 16'h0020, "R9 accepted after release");
    postIdeEn = 1;
    req(3, 'h1F2, 16'h0000, "R3 ide posted");
    req(3, 'h1F3, 16'h0000, "R11 ide posted no block");
    postIdeEn = 0;

    // R4 priority across regions
    req(3, 'h300, 16'h0028, "R4 lower region not posting");
    req(1, 'h0, 16'h0, "R7 retry busy");
    rsp(0, 0, "R9 release");
    req(3, 'h300, 16'h0220, "R4 region5 posted");
    req(3, 'h300, 16'h0080, "R4 region7 io no prefetch");
    rsp(0, 0, "R9 release");
    req(3, 'h300, 16'h0000, "R4 no hit confirmed");
    rsp(1, 0, "R9 flag holdEn off");

    // R5 reads and register writes
    req(0, 'h40, 16'h0, "R5 mem read");
    rsp(0, 0, "R9 release");
    req(5, 'h40, 16'h0, "R5 reg write");
    rsp(0, 0, "R9 release");
    req(7, 'h40, 16'h0, "R5 code7 read");
    rsp(0, 0, "R9 release");

    // R8 hold
    holdEn = 1;
    req(3, 'h1F0, 16'h0, "R3 ide confirmed");
    rsp(1, 0, "R8 exception hold");
    cyc("R8 holding");
    req(1, 'h0, 16'h0, "R7 retry in hold");
    rsp(0, 0, "R8 rsp ignored in hold");
    xferDone = 1; cyc("R8 xfer done");
    cyc("R8 released");
    req(2, 'h1F0, 16'h0, "R9 io read after hold");
    rsp(0, 1, "R8 smi hold");
    xferDone = 1; cyc("R8 release smi");
    rsp(0, 0, "R9 extra rsp");
    holdEn = 0;

    // R10 outbound
    obDone = 1; obMasterAbort = 1; cyc("R10 master abort");
    obDone = 1; cyc("R10 normal end");
    obMasterAbort = 1; cyc("R10 no done");

    // reset mid-operation
    req(3, 'h1F0, 16'h0, "R3 confirmed before reset");
    rstN = 0; cyc("R1 reset again");
    rstN = 1; cyc("R1 after second reset");
    req(1, 'h0, 16'h0, "R1 not busy after reset");
    cyc("R6 idle end");
    finishRun();
  end

endmodule